// File: doc/BRIEF.md
# Serial Register Access Port

This block is a three-wire serial slave that lets a host processor read and write a small bank of 8-bit control registers. The host drives an active-low select, a serial clock and one bidirectional data line. The data line appears here as a separate input, an output and an output enable. Each transaction is a 16-bit frame, sent most significant bit first. The frame carries a 3-bit operation code, a 4-bit register address, one turnaround bit and an 8-bit data field.

All serial inputs are brought into a fast system clock domain through synchronisers, and clock edges are found there. The serial clock may stop at either level in the middle of a frame. A frame ends after 16 rising edges. If the select stays low, the next 16 edges form a new frame. The full register contents are always visible on a flat output bus, so that the logic they control can use them directly. Eleven registers exist at addresses 0x0 to 0xA. Addresses 0xB to 0xF are reserved.

Top module: `serial_reg_port`

## Requirements
- R1: Frame bits are sampled on rising edges of the serial clock. The bit count starts when select goes low. Counting the first bit as bit 15, bits 15..13 are the operation code, bits 12..9 are the address, bit 8 is a turnaround bit that is ignored, and bits 7..0 are data.
- R2: Code 3'b111 is a write and code 3'b110 is a read. Any other code changes no register and never enables the data output.
- R3: A write stores the data field in the addressed register on the 16th rising edge. If select goes high before that edge, the write is dropped.
- R4: A read enables the output from the 8th falling edge and presents data bit 7 there. Each later falling edge up to the 15th presents the next lower bit.
- R5: The output is disabled at the 16th falling edge, or at once when select goes high, whichever comes first.
- R6: While select stays low, the next 16 rising edges form a new, independent frame.
- R7: The serial clock may pause at either level anywhere in a frame without changing the result.
- R8: After reset, register 0x1 holds 0x40, register 0x3 holds 0x7F, registers 0x7 and 0x8 hold 0x1F, and all other registers hold 0x00.
- R9: Some bits cannot be written and always read 0. Only these bits are writable: register 0x4 mask 0x0F, 0x5 mask 0x3F, 0x6 mask 0x7F, 0x7 mask 0x1F, 0x8 mask 0x1F. All other registers are writable in full.
- R10: A write to an address from 0xB to 0xF changes nothing. A read from those addresses returns 0x00.
- R11: Register n appears on the register bus at bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low frame select from the host |
| sck_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data into the block |
| sdat_o | output | 1 | Serial read data |
| sdat_oe_o | output | 1 | Enable for the data line driver |
| regs_o | output | 88 | All registers, register n at bits [8n+7:8n] |

## Verification
The hardest states to reach are the read-enable window ended by select rising partway through the data, and a 16th falling edge that is also the start of a second frame under the same select. The bench builds every frame from a task that controls how many edges it produces. That task can stop with the clock held high, add a long pause after a chosen bit, and keep select low between frames. It records the output enable after every falling edge, so both ends of the window are compared edge by edge.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int OP_W     = 3;
  localparam int NUM_REGS = 11;

  localparam logic [OP_W-1:0] OP_READ  = 3'b110;
  localparam logic [OP_W-1:0] OP_WRITE = 3'b111;

  typedef enum logic [1:0] {CMD_NONE, CMD_READ, CMD_WRITE} cmd_e;

  function automatic cmd_e decode_op(input logic [OP_W-1:0] op);
    case (op)
      OP_READ:  return CMD_READ;
      OP_WRITE: return CMD_WRITE;
      default:  return CMD_NONE;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h40;
      3:       return 8'h7F;
      7, 8:    return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_wmask(input int idx);
    case (idx)
      4:       return 8'h0F;
      5:       return 8'h3F;
      6:       return 8'h7F;
      7, 8:    return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_active_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [RW-1:0] wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [RW-1:0] rd_data_i,
  output logic          sdo_o,
  output logic          oe_o
);
  localparam int HDR_W   = OP_W + AW + 1;
  localparam int FRAME_W = HDR_W + RW;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               sck_prev;
  logic               sck_rise, sck_fall;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-2:0] shreg;
  logic [RW-1:0]      out_sh;
  logic               oe_q;
  cmd_e               hdr_cmd, end_cmd;

  assign sck_rise = sck_i & ~sck_prev;
  assign sck_fall = ~sck_i & sck_prev;

  assign hdr_cmd   = decode_op(shreg[HDR_W-1 -: OP_W]);
  assign rd_addr_o = shreg[HDR_W-1-OP_W -: AW];
  assign end_cmd   = decode_op(shreg[FRAME_W-2 -: OP_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_i;
  end

  // input side: count and shift on rising edges, commit at the last one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (!cs_active_i) begin
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sck_rise) begin
        bit_cnt <= (bit_cnt == CNT_LAST) ? '0 : bit_cnt + 1'b1;
        shreg   <= {shreg[FRAME_W-3:0], sdi_i};
        if (bit_cnt == CNT_LAST && end_cmd == CMD_WRITE) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= shreg[FRAME_W-2-OP_W -: AW];
          wr_data_o <= {shreg[RW-2:0], sdi_i};
        end
      end
    end
  end

  // output side: act on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      out_sh <= '0;
    end else if (!cs_active_i) begin
      oe_q <= 1'b0;
    end else if (sck_fall) begin
      if (bit_cnt == CNT_HDR) begin
        if (hdr_cmd == CMD_READ) begin
          oe_q   <= 1'b1;
          out_sh <= rd_data_i;
        end
      end else if (bit_cnt == '0) begin
        oe_q <= 1'b0;
      end else if (oe_q) begin
        out_sh <= {out_sh[RW-2:0], 1'b0};
      end
    end
  end

  assign sdo_o = out_sh[RW-1];
  assign oe_o  = oe_q;

  p_commit_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(sck_rise) && $past(cs_active_i));
  p_drive_from_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(sck_fall));
  p_release_on_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> !oe_q);
  p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active_i |=> bit_cnt == '0);
endmodule

// File: rtl/srp_regbank.sv
module srp_regbank
  import srp_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W,
  parameter int N  = NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [RW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [RW-1:0] rd_data_o,
  output logic [N*RW-1:0] regs_o
);
  logic [RW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [RW-1:0] DEF  = reg_default(g);
    localparam logic [RW-1:0] MASK = reg_wmask(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= DEF & MASK;
      else if (wr_en_i && wr_addr_i == AW'(g))     regs[g] <= wr_data_i & MASK;
    end
    assign regs_o[g*RW +: RW] = regs[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = regs[i];
  end

  p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_o));
  p_reserved_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i >= AW'(N)) |=> $stable(regs_o));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RW          = REG_W,
  parameter int AW          = ADDR_W,
  parameter int N           = NUM_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n_i,
  input  logic          sck_i,
  input  logic          sdat_i,
  output logic          sdat_o,
  output logic          sdat_oe_o,
  output logic [N*RW-1:0] regs_o
);
  logic [2:0]    raw_v, syn_v;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [RW-1:0] wr_data, rd_data;
  logic          oe_int;

  assign raw_v = {sdat_i, sck_i, sel_n_i};

  srp_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_v), .sync_o(syn_v)
  );

  srp_frame #(.RW(RW), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_active_i(~syn_v[0]), .sck_i(syn_v[1]), .sdi_i(syn_v[2]),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .sdo_o(sdat_o), .oe_o(oe_int)
  );

  srp_regbank #(.RW(RW), .AW(AW), .N(N)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o(regs_o)
  );

  // drop the driver as soon as select rises, without waiting for the synchroniser
  assign sdat_oe_o = oe_int & ~sel_n_i;

  p_quiet_when_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_i |-> !sdat_oe_o);
endmodule

// File: tb/sim_serial_reg_port.sv
`timescale 1ns/1ps
module sim_serial_reg_port;
  localparam int HALF = 8;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, sck = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [87:0] regs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_reg_port u0 (.clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck),
    .sdat_i(sdi), .sdat_o(sdo), .sdat_oe_o(sdo_oe), .regs_o(regs));

  function automatic logic [7:0] exp_def(int i);
    case (i) 1: return 8'h40; 3: return 8'h7F; 7, 8: return 8'h1F; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_mask(int i);
    case (i) 4: return 8'h0F; 5: return 8'h3F; 6: return 8'h7F; 7, 8: return 8'h1F;
      default: return 8'hFF; endcase
  endfunction

  logic [7:0] model [11];

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_bus(string req);
    logic [87:0] e;
    for (int i = 0; i < 11; i++) e[i*8 +: 8] = model[i];
    chk(regs === e, req, regs[63:0], e[63:0]);
    chk(regs[87:64] === e[87:64], req, 64'(regs[87:64]), 64'(e[87:64]));
  endtask

  task automatic run_frame(input logic [15:0] w, input int rises, input int pause_at,
                           input bit drop_cs, output logic [7:0] got,
                           output logic [15:0] oe_seen, output bit oe_pre);
    got = '0; oe_seen = '0;
    sel_n = 0; wait_clk(HALF);
    for (int i = 0; i < rises; i++) begin
      sdi = w[15-i]; wait_clk(HALF);
      sck = 1; wait_clk(HALF);
      if (i == pause_at) wait_clk(150);
      if (i + 1 == rises && rises < 16) break;
      sck = 0; wait_clk(HALF);
      if (i == pause_at) wait_clk(150);
      oe_seen[i] = sdo_oe;
      if (i >= 7 && i <= 14) got[14-i] = sdo;
    end
    oe_pre = sdo_oe;
    if (drop_cs) begin
      sel_n = 1; wait_clk(1);
      chk(sdo_oe == 1'b0, "R5 release on deselect", 64'(sdo_oe), 0);
      wait_clk(HALF); sck = 0; wait_clk(HALF);
    end
  endtask

  function automatic logic [15:0] mkw(logic [2:0] op, logic [3:0] a, logic [7:0] d);
    return {op, a, 1'b0, d};
  endfunction

  task automatic do_write(logic [3:0] a, logic [7:0] d);
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b111, a, d), 16, -1, 1, g, o, p);
    if (a < 11) model[a] = d & exp_mask(a);
  endtask

  task automatic do_read(logic [3:0] a, logic [7:0] exp, string req);
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b110, a, 8'h00), 16, -1, 1, g, o, p);
    chk(g === exp, req, 64'(g), 64'(exp));
    chk(o === 16'h7F80, {req, " R4 R5 drive window"}, 64'(o), 64'h7F80);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 11; i++) model[i] = exp_def(i) & exp_mask(i);
    chk_bus("R8 R11 reset values");
    chk(sdo_oe == 0, "R8 idle output off", 64'(sdo_oe), 0);
    do_read(4'h3, 8'h7F, "R8 serial read of default");
  endtask

  task automatic t_write_read;
    do_write(4'h2, 8'hA5);
    chk_bus("R3 R11 write reaches bus");
    do_read(4'h2, 8'hA5, "R1 R4 read back");
    do_write(4'hA, 8'h3C);
    chk_bus("R11 top register slice");
    do_read(4'hA, 8'h3C, "R1 read last register");
  endtask

  task automatic t_masks;
    do_write(4'h4, 8'hFF);
    chk_bus("R9 masked write bus");
    do_read(4'h4, 8'h0F, "R9 masked read");
    do_write(4'h6, 8'hFF);
    do_read(4'h6, 8'h7F, "R9 mask reg6");
  endtask

  task automatic t_bad_op;
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b101, 4'h0, 8'h33), 16, -1, 1, g, o, p);
    chk_bus("R2 unknown code no write");
    chk(o === 16'h0, "R2 unknown code no drive", 64'(o), 0);
    run_frame(mkw(3'b010, 4'h1, 8'h99), 16, -1, 1, g, o, p);
    chk_bus("R2 code 010 no write");
    chk(o === 16'h0, "R2 code 010 no drive", 64'(o), 0);
  endtask

  task automatic t_cancel;
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b111, 4'h0, 8'h77), 15, -1, 1, g, o, p);
    chk_bus("R3 write cancelled before 16th rise");
    run_frame(mkw(3'b110, 4'h2, 8'h00), 12, -1, 1, g, o, p);
    chk(p == 1'b1, "R5 driving before deselect", 64'(p), 1);
    chk(o === 16'h0780, "R4 window before cancel", 64'(o), 64'h0780);
    do_read(4'h2, 8'hA5, "R5 clean read after cancel");
  endtask

  task automatic t_back2back;
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b111, 4'h9, 8'h5A), 16, -1, 0, g, o, p);
    model[9] = 8'h5A;
    run_frame(mkw(3'b110, 4'h9, 8'h00), 16, -1, 0, g, o, p);
    chk(g === 8'h5A, "R6 back-to-back read", 64'(g), 64'h5A);
    chk(o === 16'h7F80, "R6 back-to-back window", 64'(o), 64'h7F80);
    run_frame(mkw(3'b111, 4'h0, 8'hC3), 16, -1, 1, g, o, p);
    model[0] = 8'hC3;
    chk_bus("R6 third frame write");
  endtask

  task automatic t_pause;
    logic [7:0] g; logic [15:0] o; bit p;
    run_frame(mkw(3'b111, 4'h5, 8'h96), 16, 5, 1, g, o, p);
    model[5] = 8'h96 & 8'h3F;
    chk_bus("R7 write with pause");
    run_frame(mkw(3'b110, 4'h5, 8'h00), 16, 10, 1, g, o, p);
    chk(g === 8'h16, "R7 read with pause", 64'(g), 64'h16);
  endtask

  task automatic t_reserved;
    do_write(4'hC, 8'hEE);
    chk_bus("R10 reserved write ignored");
    do_read(4'hC, 8'h00, "R10 reserved read");
    do_read(4'hB, 8'h00, "R10 reserved read B");
  endtask

  initial begin
    wait_clk(10); rst_n = 1; wait_clk(10);
    t_reset; t_write_read; t_masks; t_bad_op; t_cancel;
    t_back2back; t_pause; t_reserved;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule